// File: doc/BRIEF.md
# Configurable Mesh Functional Unit

One processing node of a coarse-grained reconfigurable mesh with a 16-bit datapath. Each cycle it can accept a left operand, a right operand and a value from a skip bus. The left operand goes through a barrel shifter. The right operand reaches the ALU unshifted. The ALU is either a per-bit two-input lookup table or an adder, depending on the configuration. A condition stage derives a one-bit flag from the ALU result. An output selector picks the value that leaves the unit on the main output.

All behaviour comes from a 24-bit configuration word. The word is written through a dedicated write strobe while the unit is being reconfigured. The main result and its flag pass through a programmable delay chain, so that paths of different lengths in the mesh arrive in step. The skip bus is re-registered with a fixed single-cycle delay, which lets operands hop past this unit to nodes further along.

Top module: `mesh_fu`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `skip_out` is 0.
- R2: The left operand is shifted by the amount in config bits [8:5]. Bit 10 = 1 shifts toward the MSB and 0 shifts toward the LSB. Bit 9 = 1 rotates and 0 zero-fills. The shifted value is visible when the output source is 1.
- R3: The right operand is never shifted. It reaches the ALU and output source 2 unchanged, whatever the shift setting.
- R4: With config bit 4 = 0, result bit i equals config bit {L[i], R[i]}. L is the shifted left operand and R is the right operand, so index 0 is L=0,R=0 and index 3 is L=1,R=1.
- R5: With config bit 4 = 1, the result is (L + R) mod 2^16, and the carry is bit 16 of the sum. In lookup mode the carry is 0.
- R6: Config bits [15:14] choose the flag: 0 = result is zero, 1 = result bit 15, 2 = carry, 3 = constant 1. The flag stays with its own result through the delay chain.
- R7: Config bits [17:16] choose the main output: 0 = ALU result, 1 = shifted left operand, 2 = right operand, 3 = skip input.
- R8: An input accepted with `in_valid` appears with `out_valid` exactly 1+D clock edges later. D is config bits [13:11], and values above 4 act as 4.
- R9: `skip_out` equals `skip_in` from one edge earlier, regardless of configuration or configuration writes.
- R10: A configuration write applies from the next cycle on. Every result already in the delay chain, and any input offered in the same cycle as the write, is dropped and never raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 24 | Configuration word |
| in_valid | input | 1 | Operands present this cycle |
| left_in | input | 16 | Left operand (shiftable) |
| right_in | input | 16 | Right operand |
| skip_in | input | 16 | Skip bus input |
| out_valid | output | 1 | Main output carries a result |
| out_data | output | 16 | Main output value |
| out_flag | output | 1 | Condition flag of the result |
| skip_out | output | 16 | Skip bus output, one cycle late |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that a configuration word arrives only through `cfg_we`, so that any valid output must have been produced under the configuration currently held. The stimulus never changes the configuration without the strobe. It issues one operand set at a time during the sweeps, which keeps each result's latency window free of other traffic. Overlapping traffic appears only in the flush test, where the dropped results are the point of the test.

// File: rtl/mesh_fu.sv
module mesh_fu #(
  parameter int W    = 16,
  parameter int CW   = 24,
  parameter int MAXD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_data,
  input  logic          in_valid,
  input  logic [W-1:0]  left_in,
  input  logic [W-1:0]  right_in,
  input  logic [W-1:0]  skip_in,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          out_flag,
  output logic [W-1:0]  skip_out
);
  localparam int EW = W + 2;
  localparam logic [2:0] DMAX = 3'(MAXD);

  logic [CW-1:0] cfg_q;
  logic [3:0]    amt;
  logic [W-1:0]  l_sh, lut_res, alu_res, sel_res;
  logic [W:0]    sum;
  logic          carry, flag;
  logic [2:0]    dsel;
  logic [EW-1:0] stg [0:MAXD];

  assign amt = cfg_q[8:5];

  always_comb begin
    logic [2*W-1:0] dbl;
    if (cfg_q[10]) begin
      dbl  = {left_in, left_in} << amt;
      l_sh = cfg_q[9] ? dbl[2*W-1:W] : (left_in << amt);
    end else begin
      dbl  = {left_in, left_in} >> amt;
      l_sh = cfg_q[9] ? dbl[W-1:0] : (left_in >> amt);
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_lut
    assign lut_res[i] = cfg_q[{l_sh[i], right_in[i]}];
  end

  assign sum     = {1'b0, l_sh} + {1'b0, right_in};
  assign alu_res = cfg_q[4] ? sum[W-1:0] : lut_res;
  assign carry   = cfg_q[4] & sum[W];

  always_comb begin
    case (cfg_q[15:14])
      2'd0:    flag = (alu_res == '0);
      2'd1:    flag = alu_res[W-1];
      2'd2:    flag = carry;
      default: flag = 1'b1;
    endcase
    case (cfg_q[17:16])
      2'd0:    sel_res = alu_res;
      2'd1:    sel_res = l_sh;
      2'd2:    sel_res = right_in;
      default: sel_res = skip_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      stg[0]   <= '0;
      skip_out <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_data;
      stg[0]   <= {in_valid & ~cfg_we, flag, sel_res};
      skip_out <= skip_in;
    end
  end

  for (genvar s = 1; s <= MAXD; s++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n || cfg_we) stg[s] <= '0;
      else                  stg[s] <= stg[s-1];
    end
  end

  assign dsel = (cfg_q[13:11] > DMAX) ? DMAX : cfg_q[13:11];
  assign {out_valid, out_flag, out_data} = stg[dsel];
endmodule

// File: rtl/mesh_fu_chk.sv
module mesh_fu_chk #(
  parameter int W  = 16,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          in_valid,
  input logic [W-1:0]  skip_in,
  input logic [W-1:0]  skip_out,
  input logic          out_valid,
  input logic          out_flag,
  input logic [CW-1:0] cfg_q
);
  p_skip_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> skip_out == $past(skip_in));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> !out_valid);

  p_zero_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we) && cfg_q[13:11] == 3'd0) |-> out_valid == $past(in_valid));

  p_const_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_q[15:14] == 2'd3) |-> out_flag);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && skip_out == '0));
endmodule

bind mesh_fu mesh_fu_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_valid(in_valid),
  .skip_in(skip_in), .skip_out(skip_out), .out_valid(out_valid),
  .out_flag(out_flag), .cfg_q(cfg_q));

// File: tb/mesh_fu_test.sv
module mesh_fu_test;
  logic        clk = 0, rst_n = 0, cfg_we = 0, in_valid = 0;
  logic [23:0] cfg_data = '0;
  logic [15:0] left_in = '0, right_in = '0, skip_in = '0;
  logic        out_valid, out_flag;
  logic [15:0] out_data, skip_out;
  int checks = 0, fails = 0;
  logic [23:0] cur;

  mesh_fu uut (.*);

  always #4 clk = ~clk;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] shf(input logic [15:0] v, input int a, input bit rot, input bit lft);
    logic [15:0] x = v;
    for (int k = 0; k < a; k++) begin
      if (lft) x = {x[14:0], rot ? x[15] : 1'b0};
      else     x = {rot ? x[0] : 1'b0, x[15:1]};
    end
    return x;
  endfunction

  function automatic logic [16:0] model(input logic [23:0] c, input logic [15:0] l, input logic [15:0] r, input logic [15:0] s);
    logic [15:0] ls, res, o;
    logic cy, f;
    int t;
    ls = shf(l, int'(c[8:5]), c[9], c[10]);
    cy = 0;
    if (c[4]) begin
      t = int'(ls) + int'(r);
      res = t[15:0];
      cy = t[16];
    end else
      for (int i = 0; i < 16; i++) res[i] = c[2*ls[i] + r[i]];
    case (c[15:14])
      0: f = (res == 0);
      1: f = res[15];
      2: f = cy;
      default: f = 1;
    endcase
    case (c[17:16])
      0: o = res;
      1: o = ls;
      2: o = r;
      default: o = s;
    endcase
    return {f, o};
  endfunction

  task automatic wr_cfg(input logic [23:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_data = c; cur = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic op(input logic [15:0] l, input logic [15:0] r, input logic [15:0] s, input string tag);
    logic [16:0] e;
    int d;
    e = model(cur, l, r, s);
    d = (cur[13:11] > 4) ? 4 : int'(cur[13:11]);
    left_in = l; right_in = r; skip_in = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    for (int k = 0; k < d; k++) begin
      chk(!out_valid, {tag, " early"}, out_valid, 0);
      @(negedge clk);
    end
    chk(out_valid, {tag, " valid"}, out_valid, 1);
    chk(out_data == e[15:0], {tag, " data"}, out_data, e[15:0]);
    chk(out_flag == e[16], {tag, " flag"}, out_flag, e[16]);
  endtask

  function automatic logic [23:0] mk(input int lut, input bit add, input int amt, input bit rot,
                                     input bit lft, input int dly, input int cnd, input int src);
    return {6'd0, 2'(src), 2'(cnd), 3'(dly), lft, rot, 4'(amt), add, 4'(lut)};
  endfunction

  initial begin
    cur = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && skip_out == 0, "R1 reset", {out_valid, skip_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && skip_out == 0, "R1 after reset", {out_valid, skip_out}, 0);

    for (int dir = 0; dir < 2; dir++)
      for (int rt = 0; rt < 2; rt++)
        for (int a = 0; a < 16; a++) begin
          wr_cfg(mk(0, 0, a, rt[0], dir[0], 0, 3, 1));
          op(16'hB3C5, 16'h0, 16'h0, "R2 shift");
          op(16'h8001, 16'h0, 16'h0, "R2 shift");
        end

    for (int a = 0; a < 16; a += 5) begin
      wr_cfg(mk(0, 0, a, 1, 1, 0, 0, 2));
      op(16'hF0F0, 16'h1234, 16'h0, "R3 src right");
      wr_cfg(mk(4'b1010, 0, a, 0, 0, 0, 0, 0));
      op(16'hF0F0, 16'hA55A, 16'h0, "R3 alu right");
    end

    for (int lut = 0; lut < 16; lut++) begin
      wr_cfg(mk(lut, 0, 0, 0, 0, 0, 0, 0));
      op(16'hFF00, 16'hF0F0, 16'h0, "R4 lut");
      op(16'h0000, 16'h0000, 16'h0, "R4 lut");
      op(16'h5A3C, 16'hC3A5, 16'h0, "R4 lut");
    end

    for (int cnd = 0; cnd < 4; cnd++) begin
      wr_cfg(mk(0, 1, 0, 0, 0, 0, cnd, 0));
      op(16'hFFFF, 16'h0001, 16'h0, "R5 R6 add wrap");
      op(16'h7FFF, 16'h0001, 16'h0, "R5 R6 add sign");
      op(16'h1234, 16'h4321, 16'h0, "R5 R6 add");
      op(16'h8000, 16'h8000, 16'h0, "R5 R6 add carry");
      wr_cfg(mk(4'b1110, 0, 0, 0, 0, 0, cnd, 0));
      op(16'hFFFF, 16'hFFFF, 16'h0, "R6 lut flag");
      op(16'h0000, 16'h0000, 16'h0, "R6 lut flag");
    end

    for (int src = 0; src < 4; src++) begin
      wr_cfg(mk(4'b0110, 0, 3, 0, 1, 0, 1, src));
      op(16'h1357, 16'h2468, 16'hBEEF, "R7 source");
    end

    for (int d = 0; d < 8; d++) begin
      wr_cfg(mk(0, 1, 1, 0, 1, d, 1, 0));
      op(16'h4001, 16'h0003, 16'h0, "R8 depth");
    end

    for (int k = 0; k < 20; k++) begin
      logic [15:0] v = 16'(k * 16'h1357 + 16'h0F1);
      skip_in = v;
      if (k == 7) begin cfg_we = 1; cfg_data = mk(1, 0, 0, 0, 0, 2, 0, 0); cur = cfg_data; end
      @(negedge clk);
      cfg_we = 0;
      chk(skip_out == v, "R9 skip delay", skip_out, v);
    end

    wr_cfg(mk(0, 1, 0, 0, 0, 4, 3, 0));
    left_in = 16'h1; right_in = 16'h2; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    cfg_we = 1; cfg_data = mk(0, 1, 0, 0, 0, 1, 3, 0); cur = cfg_data;
    in_valid = 1;
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    for (int k = 0; k < 7; k++) begin
      chk(!out_valid, "R10 flushed", out_valid, 0);
      @(negedge clk);
    end
    wr_cfg(mk(0, 1, 2, 0, 1, 0, 2, 0));
    op(16'h4000, 16'h0005, 16'h0, "R10 new cfg next cycle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule